// File: doc/BRIEF.md
# Grouped System Management Interrupt Aggregator

This block folds a set of interrupt sources into one system management interrupt and sends that interrupt to up to three destinations. The sources come in two classes. Device-level sources (parallel port, two serial ports, floppy, mouse, keyboard, infrared) are level signals owned by their devices. Each is synchronised and gated by its own enable bit. The infrared source is the one exception: its rising edge sets a local flag, and a read of the device status register clears that flag. General-purpose and tachometer sources go through edge detectors. The edge that counts is chosen per bit: rising, falling or both. A detected edge sets a sticky status bit, which software clears by writing 1.

The combined interrupt has three routes, each with its own enable: a dedicated pad, a request into the serial interrupt slot logic, and a request into the power-management event logic. The pad can be set active high or active low, and open-drain or push-pull. The block provides only an output-enable and a data-out signal for the pad. An 8-bit register bus with byte addresses gives access to all enables, status bits and configuration.

Top module: `smi_hub`

## Requirements
- R1: The internal interrupt is the OR, over the device sources, of each synchronised level ANDed with its enable bit in DEV_EN (address 0x1). Bit 0 is parallel, 1 serial A, 2 serial B, 3 floppy, 4 mouse, 5 keyboard and 6 infrared. A change on a device input reaches the outputs after two clock edges.
- R2: A read of DEV_STS (address 0x0) returns the synchronised device levels in bits 5:0 and the infrared flag in bit 6. Bit 7 reads 0. Writes to 0x0 have no effect.
- R3: A synchronised rising edge on the infrared input sets the infrared flag. A read of address 0x0 returns the flag's value and clears it after that read cycle. If a set and a read clear fall in the same cycle, the set wins.
- R4: For an edge source whose bit in EDGE_INV is 0, a synchronised rising edge sets its status bit. When the EDGE_INV bit is 1, a falling edge sets it instead.
- R5: For an edge source whose bit in EDGE_BOTH is 1, both rising and falling edges set its status bit, whatever its EDGE_INV bit holds.
- R6: Writing 1 to a bit of EDGE_STS clears that status bit. Writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: An edge source adds to the interrupt only through its latched status bit ANDed with its EDGE_EN bit. The status bit keeps its value after the input returns, and it has no effect while its enable bit is 0.
- R8: ROUTE (address 0x2) gates the interrupt onto three outputs. Bit 7 drives the pad assertion, bit 6 drives smi_irq_req_o and bit 5 drives smi_pme_req_o. The other bits read 0.
- R9: PIN_CFG (address 0x3) sets the pad behaviour. Bit 0 set to 1 makes the pad active high, and bit 7 set to 1 selects push-pull. In push-pull the pad is always driven (oe=1) with the pin level. In open-drain the pad is driven (oe=1, do=0) only when the pin level is low, and released (oe=0) otherwise.
- R10: After reset every enable, route, configuration and status bit is 0. The pad is therefore active low and open-drain and is released, and both request outputs are 0.
- R11: Registers are 8 bits wide at byte addresses. For an edge source group of NB = EDGE_N/8 bytes, byte b of EDGE_STS is at 0x4+b, EDGE_EN at 0x4+NB+b, EDGE_INV at 0x4+2NB+b and EDGE_BOTH at 0x4+3NB+b. Bit i of byte b is source 8b+i. Unmapped addresses read 0, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_evt_i | input | 7 | Device-level interrupt sources, asynchronous |
| edge_evt_i | input | EDGE_N | GPIO and tachometer sources, asynchronous |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| smi_pad_oe_o | output | 1 | Pad output enable |
| smi_pad_do_o | output | 1 | Pad data out |
| smi_irq_req_o | output | 1 | Request into the serial interrupt slot logic |
| smi_pme_req_o | output | 1 | Request into the power-management event logic |

## Verification
The device path is driven with single sources and with several sources at once, with enable bits toggled while a source is held high. This separates the enable gating from plain passthrough. The edge sources get rising, falling and both-edge transitions, with every combination of polarity and both-edge bits. This distinguishes the three edge modes and shows that the latched status keeps a source active after its input drops. Clears are written with 0, with 1, and in the same cycle as a new edge, to confirm the set-wins rule. Every combination of pad polarity and drive type is tried both with the interrupt asserted and with it idle, along with each route bit on its own. A behavioural model in the bench tracks all of this on every clock.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int DEV_N  = 7;
    localparam int DEV_IR = 6;
    localparam int REG_W  = 8;

    localparam int A_DEV_STS   = 0;
    localparam int A_DEV_EN    = 1;
    localparam int A_ROUTE     = 2;
    localparam int A_PIN       = 3;
    localparam int A_EDGE_BASE = 4;

    localparam int ROUTE_PIN_BIT = 7;
    localparam int ROUTE_IRQ_BIT = 6;
    localparam int ROUTE_PME_BIT = 5;
    localparam int PIN_HI_BIT    = 0;
    localparam int PIN_PP_BIT    = 7;

    typedef enum logic [1:0] {
        GRP_STS  = 2'd0,
        GRP_EN   = 2'd1,
        GRP_INV  = 2'd2,
        GRP_BOTH = 2'd3
    } edge_grp_e;

    function automatic int edge_addr(edge_grp_e g, int nb, int b);
        return A_EDGE_BASE + int'(g) * nb + b;
    endfunction
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];
endmodule

// File: rtl/smi_edge_bank.sv
module smi_edge_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] inv,
    input  logic [N-1:0] both,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sts
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] sts;
    } bank_t;

    bank_t b_d, b_q;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_det
        logic rise, fall;
        assign rise   = lvl[i] & ~b_q.prev[i];
        assign fall   = ~lvl[i] & b_q.prev[i];
        assign hit[i] = both[i] ? (rise | fall) : (inv[i] ? fall : rise);

        // R4: a selected edge always leaves the status bit set
        p_set_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> b_q.sts[i]);
        // R6: write-1 clear without a competing edge empties the bit
        p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !hit[i]) |=> !b_q.sts[i]);
        // R7: the status bit is sticky without a clear
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (b_q.sts[i] && !clr[i]) |=> b_q.sts[i]);
    end

    always_comb begin
        b_d      = b_q;
        b_d.prev = lvl;
        b_d.sts  = (b_q.sts & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign sts = b_q.sts;
endmodule

// File: rtl/smi_pin_drv.sv
module smi_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic assert_in,
    input  logic active_high,
    input  logic push_pull,
    output logic pad_oe,
    output logic pad_do
);
    logic level;

    always_comb begin
        level = active_high ? assert_in : ~assert_in;
        if (push_pull) begin
            pad_oe = 1'b1;
            pad_do = level;
        end else begin
            pad_oe = ~level;
            pad_do = 1'b0;
        end
    end

    // R9: open-drain never drives a high level onto the pad
    p_od_no_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> !(pad_oe && pad_do));
    // R9: active-low open-drain pulls the pad exactly while asserted
    p_od_low_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && !active_high) |-> (pad_oe == assert_in));
endmodule

// File: rtl/smi_hub.sv
module smi_hub
    import smi_pkg::*;
#(
    parameter int EDGE_N      = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_N-1:0]  dev_evt_i,
    input  logic [EDGE_N-1:0] edge_evt_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              smi_pad_oe_o,
    output logic              smi_pad_do_o,
    output logic              smi_irq_req_o,
    output logic              smi_pme_req_o
);
    localparam int NB = EDGE_N / REG_W;

    typedef struct packed {
        logic [DEV_N-1:0]  dev_en;
        logic              route_pin;
        logic              route_irq;
        logic              route_pme;
        logic              pin_hi;
        logic              pin_pp;
        logic              ir_sts;
        logic              ir_prev;
        logic [EDGE_N-1:0] e_en;
        logic [EDGE_N-1:0] e_inv;
        logic [EDGE_N-1:0] e_both;
    } regs_t;

    regs_t r_d, r_q;

    logic [DEV_N-1:0]  dev_s;
    logic [EDGE_N-1:0] edge_s;
    logic [EDGE_N-1:0] edge_clr;
    logic [EDGE_N-1:0] edge_sts;
    logic              ir_rise;
    logic              dev_rd;
    logic              smi_int;

    function automatic logic wr_at(int a);
        return bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(a));
    endfunction

    smi_sync #(.W(DEV_N), .STAGES(SYNC_STAGES)) u_dev_sync (
        .clk(clk), .rst_n(rst_n), .din(dev_evt_i), .dout(dev_s)
    );

    smi_sync #(.W(EDGE_N), .STAGES(SYNC_STAGES)) u_edge_sync (
        .clk(clk), .rst_n(rst_n), .din(edge_evt_i), .dout(edge_s)
    );

    smi_edge_bank #(.N(EDGE_N)) u_bank (
        .clk(clk), .rst_n(rst_n), .lvl(edge_s), .inv(r_q.e_inv),
        .both(r_q.e_both), .clr(edge_clr), .sts(edge_sts)
    );

    always_comb begin
        r_d      = r_q;
        edge_clr = '0;

        ir_rise   = dev_s[DEV_IR] & ~r_q.ir_prev;
        dev_rd    = bus_sel_i && !bus_wr_i && (bus_addr_i == ADDR_W'(A_DEV_STS));
        r_d.ir_prev = dev_s[DEV_IR];
        r_d.ir_sts  = ir_rise | (r_q.ir_sts & ~dev_rd);

        if (wr_at(A_DEV_EN)) r_d.dev_en = bus_wdata_i[DEV_N-1:0];
        if (wr_at(A_ROUTE)) begin
            r_d.route_pin = bus_wdata_i[ROUTE_PIN_BIT];
            r_d.route_irq = bus_wdata_i[ROUTE_IRQ_BIT];
            r_d.route_pme = bus_wdata_i[ROUTE_PME_BIT];
        end
        if (wr_at(A_PIN)) begin
            r_d.pin_hi = bus_wdata_i[PIN_HI_BIT];
            r_d.pin_pp = bus_wdata_i[PIN_PP_BIT];
        end
        for (int b = 0; b < NB; b++) begin
            if (wr_at(edge_addr(GRP_STS, NB, b)))  edge_clr[b*REG_W +: REG_W] = bus_wdata_i;
            if (wr_at(edge_addr(GRP_EN, NB, b)))   r_d.e_en[b*REG_W +: REG_W] = bus_wdata_i;
            if (wr_at(edge_addr(GRP_INV, NB, b)))  r_d.e_inv[b*REG_W +: REG_W] = bus_wdata_i;
            if (wr_at(edge_addr(GRP_BOTH, NB, b))) r_d.e_both[b*REG_W +: REG_W] = bus_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(A_DEV_STS)) begin
            bus_rdata_o[DEV_IR-1:0] = dev_s[DEV_IR-1:0];
            bus_rdata_o[DEV_IR]     = r_q.ir_sts;
        end
        if (bus_addr_i == ADDR_W'(A_DEV_EN)) bus_rdata_o[DEV_N-1:0] = r_q.dev_en;
        if (bus_addr_i == ADDR_W'(A_ROUTE)) begin
            bus_rdata_o[ROUTE_PIN_BIT] = r_q.route_pin;
            bus_rdata_o[ROUTE_IRQ_BIT] = r_q.route_irq;
            bus_rdata_o[ROUTE_PME_BIT] = r_q.route_pme;
        end
        if (bus_addr_i == ADDR_W'(A_PIN)) begin
            bus_rdata_o[PIN_HI_BIT] = r_q.pin_hi;
            bus_rdata_o[PIN_PP_BIT] = r_q.pin_pp;
        end
        for (int b = 0; b < NB; b++) begin
            if (bus_addr_i == ADDR_W'(edge_addr(GRP_STS, NB, b)))  bus_rdata_o = edge_sts[b*REG_W +: REG_W];
            if (bus_addr_i == ADDR_W'(edge_addr(GRP_EN, NB, b)))   bus_rdata_o = r_q.e_en[b*REG_W +: REG_W];
            if (bus_addr_i == ADDR_W'(edge_addr(GRP_INV, NB, b)))  bus_rdata_o = r_q.e_inv[b*REG_W +: REG_W];
            if (bus_addr_i == ADDR_W'(edge_addr(GRP_BOTH, NB, b))) bus_rdata_o = r_q.e_both[b*REG_W +: REG_W];
        end
    end

    assign smi_int = (|(dev_s[DEV_IR-1:0] & r_q.dev_en[DEV_IR-1:0]))
                   | (r_q.ir_sts & r_q.dev_en[DEV_IR])
                   | (|(edge_sts & r_q.e_en));

    assign smi_irq_req_o = smi_int & r_q.route_irq;
    assign smi_pme_req_o = smi_int & r_q.route_pme;

    smi_pin_drv u_pin (
        .clk(clk), .rst_n(rst_n), .assert_in(smi_int & r_q.route_pin),
        .active_high(r_q.pin_hi), .push_pull(r_q.pin_pp),
        .pad_oe(smi_pad_oe_o), .pad_do(smi_pad_do_o)
    );

    // R3: infrared rising edge leaves the flag set
    p_ir_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ir_rise |=> r_q.ir_sts);
    // R3: a status read without a new edge empties the flag
    p_ir_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd && !ir_rise) |=> !r_q.ir_sts);
    // R2: a write to the device status address leaves the enables untouched
    p_dev_sts_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(A_DEV_STS)) |=> $stable(r_q.dev_en));
    // R8: a route request implies the combined interrupt is live
    p_route_needs_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_irq_req_o || smi_pme_req_o) |-> smi_int);
endmodule

// File: tb/sim_smi_hub.sv
`timescale 1ns/1ps
module sim_smi_hub;
    localparam int EDGE_N = 16;
    localparam int ADDR_W = 4;
    localparam int NB     = EDGE_N / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [6:0]        dev_evt = '0;
    logic [EDGE_N-1:0] edge_evt = '0;
    logic              sel = 1'b0, wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              pad_oe, pad_do, irq_req, pme_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    smi_hub #(.EDGE_N(EDGE_N), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_evt_i(dev_evt), .edge_evt_i(edge_evt),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .smi_pad_oe_o(pad_oe), .smi_pad_do_o(pad_do),
        .smi_irq_req_o(irq_req), .smi_pme_req_o(pme_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [6:0]        m_den;
    logic [2:0]        m_route;   // [2]=pin [1]=irq [0]=pme
    logic              m_hi, m_pp, m_ir, m_ir_prev;
    logic [EDGE_N-1:0] m_en, m_inv, m_both, m_sts, m_eprev;
    logic [6:0]        dq[$];
    logic [EDGE_N-1:0] eq[$];

    function automatic logic [6:0] dev_seen();
        return (dq.size() == 2) ? dq[0] : 7'd0;
    endfunction
    function automatic logic [EDGE_N-1:0] edge_seen();
        return (eq.size() == 2) ? eq[0] : '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_den = '0; m_route = '0; m_hi = 0; m_pp = 0; m_ir = 0; m_ir_prev = 0;
            m_en = '0; m_inv = '0; m_both = '0; m_sts = '0; m_eprev = '0;
            dq.delete(); eq.delete();
        end else begin
            logic [6:0] ds;
            logic [EDGE_N-1:0] es, clr;
            logic ir_new;
            ds = dev_seen();
            es = edge_seen();
            clr = '0;
            for (int k = 0; k < NB; k++)
                if (sel && wr && addr == 4 + k) clr[k*8 +: 8] = wdata;
            for (int i = 0; i < EDGE_N; i++) begin
                logic r, f, s;
                r = es[i] && !m_eprev[i];
                f = !es[i] && m_eprev[i];
                s = m_both[i] ? (r || f) : (m_inv[i] ? f : r);
                if (clr[i]) m_sts[i] = 1'b0;
                if (s) m_sts[i] = 1'b1;
            end
            m_eprev = es;
            ir_new = ds[6] && !m_ir_prev;
            if (sel && !wr && addr == 0) m_ir = 1'b0;
            if (ir_new) m_ir = 1'b1;
            m_ir_prev = ds[6];
            if (sel && wr) begin
                if (addr == 1) m_den = wdata[6:0];
                if (addr == 2) m_route = wdata[7:5];
                if (addr == 3) begin m_hi = wdata[0]; m_pp = wdata[7]; end
                for (int k = 0; k < NB; k++) begin
                    if (addr == 4 + NB + k)   m_en[k*8 +: 8]   = wdata;
                    if (addr == 4 + 2*NB + k) m_inv[k*8 +: 8]  = wdata;
                    if (addr == 4 + 3*NB + k) m_both[k*8 +: 8] = wdata;
                end
            end
            dq.push_back(dev_evt); if (dq.size() > 2) void'(dq.pop_front());
            eq.push_back(edge_evt); if (eq.size() > 2) void'(eq.pop_front());
        end
    end

    function automatic logic m_smi();
        logic [6:0] ds;
        ds = dev_seen();
        return (|(ds[5:0] & m_den[5:0])) || (m_ir && m_den[6]) || (|(m_sts & m_en));
    endfunction

    function automatic logic [7:0] m_read(logic [ADDR_W-1:0] a);
        logic [7:0] v;
        logic [6:0] ds;
        ds = dev_seen();
        v = '0;
        if (a == 0) v = {1'b0, m_ir, ds[5:0]};
        if (a == 1) v = {1'b0, m_den};
        if (a == 2) v = {m_route, 5'b0};
        if (a == 3) v = {m_pp, 6'b0, m_hi};
        for (int k = 0; k < NB; k++) begin
            if (a == 4 + k)        v = m_sts[k*8 +: 8];
            if (a == 4 + NB + k)   v = m_en[k*8 +: 8];
            if (a == 4 + 2*NB + k) v = m_inv[k*8 +: 8];
            if (a == 4 + 3*NB + k) v = m_both[k*8 +: 8];
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic a, lvl, eoe, edo;
            a   = m_smi() && m_route[2];
            lvl = m_hi ? a : !a;
            eoe = m_pp ? 1'b1 : !lvl;
            edo = m_pp ? lvl : 1'b0;
            chk("R9 model pad_oe", {7'b0, pad_oe}, {7'b0, eoe});
            chk("R9 model pad_do", {7'b0, pad_do}, {7'b0, edo});
            chk("R8 model irq_req", {7'b0, irq_req}, {7'b0, m_smi() && m_route[1]});
            chk("R8 model pme_req", {7'b0, pme_req}, {7'b0, m_smi() && m_route[0]});
            if (sel && !wr) chk("R11 model rdata", rdata, m_read(addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired, sequence did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(int a, logic [7:0] d);
        @(posedge clk); #2;
        sel = 1; wr = 1; addr = ADDR_W'(a); wdata = d;
        @(posedge clk); #2;
        sel = 0; wr = 0;
    endtask

    task automatic rchk(string tag, int a, logic [7:0] exp);
        @(posedge clk); #2;
        sel = 1; wr = 0; addr = ADDR_W'(a);
        @(negedge clk);
        chk(tag, rdata, exp);
        @(posedge clk); #2;
        sel = 0;
    endtask

    task automatic set_dev(logic [6:0] v);
        @(posedge clk); #2; dev_evt = v;
    endtask

    task automatic set_edge(logic [EDGE_N-1:0] v);
        @(posedge clk); #2; edge_evt = v;
    endtask

    task automatic pad_chk(string tag, logic oe, logic d);
        chk({tag, " pad_oe"}, {7'b0, pad_oe}, {7'b0, oe});
        chk({tag, " pad_do"}, {7'b0, pad_do}, {7'b0, d});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        tick(1);
        // R10: reset state
        pad_chk("R10 reset", 1'b0, 1'b0);
        chk("R10 reset irq", {7'b0, irq_req}, 8'h00);
        chk("R10 reset pme", {7'b0, pme_req}, 8'h00);
        for (int a = 0; a < 12; a++) rchk("R10 reset reg", a, 8'h00);

        // R11: map and unused bits
        wreg(1, 8'hFF); rchk("R11 dev_en", 1, 8'h7F);
        wreg(2, 8'hFF); rchk("R11 route", 2, 8'hE0);
        wreg(3, 8'hFF); rchk("R11 pin_cfg", 3, 8'h81);
        wreg(6, 8'hA5); rchk("R11 edge_en lo", 6, 8'hA5);
        wreg(9, 8'h3C); rchk("R11 edge_inv hi", 9, 8'h3C);
        rchk("R11 unmapped 0xC", 12, 8'h00);
        rchk("R11 unmapped 0xF", 15, 8'h00);
        wreg(1, 0); wreg(2, 0); wreg(3, 0); wreg(6, 0); wreg(9, 0);

        // R1: device passthrough with enable gating
        wreg(2, 8'h80); wreg(1, 8'h02);
        set_dev(7'h02); tick(3);
        pad_chk("R1 serialA asserted", 1'b1, 1'b0);
        wreg(1, 8'h00); tick(1);
        pad_chk("R1 enable off", 1'b0, 1'b0);
        wreg(1, 8'h3F); set_dev(7'h20); tick(3);
        pad_chk("R1 keyboard asserted", 1'b1, 1'b0);
        set_dev(7'h00); tick(3);
        pad_chk("R1 source dropped", 1'b0, 1'b0);

        // R2: status readback, writes ignored
        set_dev(7'h15); tick(3);
        wreg(0, 8'hFF);
        rchk("R2 dev_sts live", 0, 8'h15);
        rchk("R2 dev_en kept", 1, 8'h3F);
        set_dev(7'h00); tick(3);
        rchk("R2 dev_sts idle", 0, 8'h00);

        // R3: infrared latch, read clears
        wreg(1, 8'h40);
        set_dev(7'h40); tick(3);
        pad_chk("R3 ir latched", 1'b1, 1'b0);
        set_dev(7'h00); tick(3);
        pad_chk("R3 ir held after drop", 1'b1, 1'b0);
        rchk("R3 ir read", 0, 8'h40);
        tick(1);
        pad_chk("R3 ir cleared by read", 1'b0, 1'b0);
        rchk("R3 ir reread", 0, 8'h00);

        // R4: polarity selection
        wreg(1, 8'h00); wreg(6, 8'h03); wreg(8, 8'h02);
        set_edge(16'h0003); tick(3);
        rchk("R4 rise only bit0", 4, 8'h01);
        pad_chk("R4 edge asserts", 1'b1, 1'b0);
        set_edge(16'h0000); tick(3);
        rchk("R4 falling sets inverted bit1", 4, 8'h03);

        // R6: write-1-to-clear
        wreg(4, 8'h00); rchk("R6 write 0 no effect", 4, 8'h03);
        wreg(4, 8'h01); rchk("R6 clear bit0", 4, 8'h02);
        wreg(4, 8'h02); rchk("R6 clear bit1", 4, 8'h00);
        tick(1);
        pad_chk("R7 cleared status deasserts", 1'b0, 1'b0);

        // R7: enable gates the latched bit
        wreg(6, 8'h00);
        set_edge(16'h0001); tick(3);
        pad_chk("R7 status masked", 1'b0, 1'b0);
        rchk("R7 status latched", 4, 8'h01);
        wreg(6, 8'h01); tick(1);
        pad_chk("R7 enable exposes status", 1'b1, 1'b0);
        set_edge(16'h0000); tick(3);
        pad_chk("R7 latched after input drop", 1'b1, 1'b0);
        wreg(4, 8'h01);

        // R5: both-edge mode
        wreg(10, 8'h04); wreg(8, 8'h04); wreg(6, 8'h04);
        set_edge(16'h0004); tick(3);
        rchk("R5 rising in both mode", 4, 8'h04);
        wreg(4, 8'h04);
        set_edge(16'h0000); tick(3);
        rchk("R5 falling in both mode", 4, 8'h04);
        wreg(4, 8'h04);

        // R6: set wins over clear in the same cycle
        wreg(6, 8'h01);
        set_edge(16'h0001); tick(3);
        set_edge(16'h0000); tick(3);
        set_edge(16'h0001);
        @(posedge clk);
        wreg(4, 8'h01);
        rchk("R6 set beats clear", 4, 8'h01);
        wreg(4, 8'h01);
        rchk("R6 cleared afterwards", 4, 8'h00);
        set_edge(16'h0000); tick(3);

        // R11: upper byte of the edge group
        wreg(7, 8'h02);
        set_edge(16'h0200); tick(3);
        rchk("R11 upper status byte", 5, 8'h02);
        pad_chk("R11 upper enable", 1'b1, 1'b0);
        wreg(5, 8'h02);
        rchk("R11 upper cleared", 5, 8'h00);
        set_edge(16'h0000); wreg(7, 8'h00); wreg(6, 8'h00); tick(3);

        // R8: routes
        wreg(1, 8'h01); set_dev(7'h01); wreg(2, 8'h40); tick(3);
        chk("R8 irq route", {7'b0, irq_req}, 8'h01);
        chk("R8 pme off", {7'b0, pme_req}, 8'h00);
        pad_chk("R8 pin off", 1'b0, 1'b0);
        wreg(2, 8'h20); tick(1);
        chk("R8 pme route", {7'b0, pme_req}, 8'h01);
        chk("R8 irq off", {7'b0, irq_req}, 8'h00);
        wreg(2, 8'hE0); tick(1);
        chk("R8 all irq", {7'b0, irq_req}, 8'h01);
        chk("R8 all pme", {7'b0, pme_req}, 8'h01);

        // R9: pin polarity and drive type
        wreg(2, 8'h80);
        wreg(3, 8'h81); tick(1); pad_chk("R9 hi pp asserted", 1'b1, 1'b1);
        wreg(3, 8'h80); tick(1); pad_chk("R9 lo pp asserted", 1'b1, 1'b0);
        wreg(3, 8'h01); tick(1); pad_chk("R9 hi od asserted", 1'b0, 1'b0);
        set_dev(7'h00); tick(3);
        pad_chk("R9 hi od idle", 1'b1, 1'b0);
        wreg(3, 8'h81); tick(1); pad_chk("R9 hi pp idle", 1'b1, 1'b0);
        wreg(3, 8'h80); tick(1); pad_chk("R9 lo pp idle", 1'b1, 1'b1);
        wreg(3, 8'h00); tick(1); pad_chk("R9 lo od idle", 1'b0, 1'b0);

        tick(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule